// File: doc/BRIEF.md
# Three-Register Nonlinear Keystream Generator

This block is a bit-serial stream cipher engine. Its 288-bit secret state is split into three nonlinear feedback shift registers of 93, 84 and 111 bits. A load strobe takes in an 80-bit key and an 80-bit initialization vector and places them in the state together with a fixed constant. The engine then steps 1152 times with no output, which mixes the key and the IV through the whole state. After that it produces one keystream bit for each plaintext bit it accepts. The ciphertext bit is the plaintext bit XORed with that keystream bit.

Decryption uses the same circuit. The same key and IV are loaded, and the ciphertext bits are sent through in the same order. The IV does not have to be secret. A new IV must be used for every session that shares a key. Outside the warm-up, the state advances only when a bit is accepted, so a slow sender never loses keystream.

Top module: `trv_keystream`

## Requirements
- R1: On a load, IV bit i goes to A-register position i+1 (state bit s(i+1)) and key bit i goes to B-register position i+1 (state bit s(94+i)), for i from 0 to 79. State bits s286, s287 and s288, the last three of register C, are set to 1. Every other state bit is cleared.
- R2: `ks_ready_o` rises exactly 1152 clock edges after the edge that samples `start_i`. It then stays high until the next load.
- R3: While `ks_ready_o` is low, `ct_valid_o` stays low and `pt_valid_i` is ignored. The warm-up is neither lengthened nor shortened, and the state is not advanced beyond the warm-up steps.
- R4: The keystream bit is z = s66^s93^s162^s177^s243^s288. On each step, three feedback bits are computed from the current state:
  - t1 = s66^s93^(s91&s92)^s171 enters the first position of B.
  - t2 = s162^s177^(s175&s176)^s264 enters the first position of C.
  - t3 = s243^s288^(s286&s287)^s69 enters the first position of A.
  
  Every other bit of each register moves one position up.
- R5: A plaintext bit accepted at one edge appears at the next edge. `ct_valid_o` is high, `ks_o` holds the keystream bit z, and `ct_o` equals `pt_i` XOR z.
- R6: In the run phase, the state advances only on an accepted bit. Idle cycles consume no keystream, and `ct_valid_o` is low after them.
- R7: `start_i` at any time aborts the current run, reloads the state and restarts the warm-up count. If `start_i` and `pt_valid_i` are high in the same cycle, the load wins and no output bit is produced.
- R8: After reset, `ks_ready_o` and `ct_valid_o` are low. `pt_valid_i` has no effect until a load is made.
- R9: Loading the same key and IV again and feeding back the ciphertext bits in order returns the original plaintext on `ct_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Load strobe: samples key and IV, restarts warm-up |
| key_i | input | 80 | Secret key, bit 0 loaded first into register B |
| iv_i | input | 80 | Initialization vector, bit 0 loaded first into register A |
| pt_i | input | 1 | Plaintext (or ciphertext) bit |
| pt_valid_i | input | 1 | Qualifies `pt_i` |
| ct_o | output | 1 | `pt_i` XOR keystream bit, registered |
| ks_o | output | 1 | Keystream bit used for the last accepted bit |
| ct_valid_o | output | 1 | `ct_o` and `ks_o` hold a new result |
| ks_ready_o | output | 1 | Warm-up finished; plaintext bits are accepted |

## Verification
Two events can land in the same cycle: a load strobe and a plaintext bit. The bench provokes this by raising `start_i` together with `pt_valid_i` in the middle of a running stream. It then expects no output in the next cycle, readiness to drop at once, and a complete new 1152-cycle warm-up whose keystream matches the new key. The bench also keeps `pt_valid_i` toggling right up to the final warm-up edge. This checks that a bit offered in the cycle when readiness rises is not taken. The first bit accepted afterwards must still match the reference model's first keystream bit.

// File: rtl/trv_pkg.sv
package trv_pkg;
  localparam int KEY_W     = 80;
  localparam int A_LEN     = 93;
  localparam int B_LEN     = 84;
  localparam int C_LEN     = 111;
  localparam int STATE_LEN = A_LEN + B_LEN + C_LEN;
  localparam int WARMUP_DEFAULT = 4 * STATE_LEN;

  // tap positions, 1-based over the whole state
  localparam int A_OUT = 66,  A_END = 93,  A_AND0 = 91,  A_AND1 = 92,  A_XB = 171;
  localparam int B_OUT = 162, B_END = 177, B_AND0 = 175, B_AND1 = 176, B_XC = 264;
  localparam int C_OUT = 243, C_END = 288, C_AND0 = 286, C_AND1 = 287, C_XA = 69;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_WARM = 2'd1,
    PH_RUN  = 2'd2
  } phase_e;
endpackage

// File: rtl/trv_seg.sv
module trv_seg #(
  parameter int LEN = 93
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [LEN-1:0] load_val_i,
  input  logic           step_i,
  input  logic           fb_i,
  output logic [LEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= load_val_i;
    else if (step_i) q_o <= {q_o[LEN-2:0], fb_i};
  end
endmodule

// File: rtl/trv_core.sv
module trv_core
  import trv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] iv_i,
  output logic             z_o
);
  logic [A_LEN-1:0] a_q;
  logic [B_LEN-1:0] b_q;
  logic [C_LEN-1:0] c_q;
  logic [STATE_LEN-1:0] s;
  logic t_a, t_b, t_c, fb_a, fb_b, fb_c;

  assign s = {c_q, b_q, a_q};  // s(p) is s[p-1]

  assign t_a  = s[A_OUT-1] ^ s[A_END-1];
  assign t_b  = s[B_OUT-1] ^ s[B_END-1];
  assign t_c  = s[C_OUT-1] ^ s[C_END-1];
  assign z_o  = t_a ^ t_b ^ t_c;
  assign fb_b = t_a ^ (s[A_AND0-1] & s[A_AND1-1]) ^ s[A_XB-1];
  assign fb_c = t_b ^ (s[B_AND0-1] & s[B_AND1-1]) ^ s[B_XC-1];
  assign fb_a = t_c ^ (s[C_AND0-1] & s[C_AND1-1]) ^ s[C_XA-1];

  logic [A_LEN-1:0] a_load;
  logic [B_LEN-1:0] b_load;
  logic [C_LEN-1:0] c_load;
  assign a_load = {{(A_LEN-KEY_W){1'b0}}, iv_i};
  assign b_load = {{(B_LEN-KEY_W){1'b0}}, key_i};
  assign c_load = {3'b111, {(C_LEN-3){1'b0}}};

  trv_seg #(.LEN(A_LEN)) i_seg_a (
    .clk_i, .rst_ni, .load_i, .load_val_i(a_load), .step_i, .fb_i(fb_a), .q_o(a_q)
  );
  trv_seg #(.LEN(B_LEN)) i_seg_b (
    .clk_i, .rst_ni, .load_i, .load_val_i(b_load), .step_i, .fb_i(fb_b), .q_o(b_q)
  );
  trv_seg #(.LEN(C_LEN)) i_seg_c (
    .clk_i, .rst_ni, .load_i, .load_val_i(c_load), .step_i, .fb_i(fb_c), .q_o(c_q)
  );
endmodule

// File: rtl/trv_ctrl.sv
module trv_ctrl
  import trv_pkg::*;
#(
  parameter int WARMUP_CYCLES = WARMUP_DEFAULT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic pt_valid_i,
  output logic step_o,
  output logic accept_o,
  output logic ready_o
);
  localparam int CNT_W = $clog2(WARMUP_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WARMUP_CYCLES - 1);

  phase_e           phase_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (start_i) begin
      phase_q <= PH_WARM;
      cnt_q   <= '0;
    end else if (phase_q == PH_WARM) begin
      if (cnt_q == CNT_LAST) phase_q <= PH_RUN;
      else                   cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign ready_o  = (phase_q == PH_RUN);
  assign accept_o = ready_o && pt_valid_i && !start_i;
  assign step_o   = (phase_q == PH_WARM) || accept_o;
endmodule

// File: rtl/trv_keystream.sv
module trv_keystream
  import trv_pkg::*;
#(
  parameter int WARMUP_CYCLES = WARMUP_DEFAULT
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [KEY_W-1:0] iv_i,
  input  logic             pt_i,
  input  logic             pt_valid_i,
  output logic             ct_o,
  output logic             ks_o,
  output logic             ct_valid_o,
  output logic             ks_ready_o
);
  logic step, accept, z;

  trv_ctrl #(.WARMUP_CYCLES(WARMUP_CYCLES)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .pt_valid_i,
    .step_o(step), .accept_o(accept), .ready_o(ks_ready_o)
  );

  trv_core i_core (
    .clk_i, .rst_ni, .load_i(start_i), .step_i(step),
    .key_i, .iv_i, .z_o(z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ct_valid_o <= 1'b0;
      ks_o       <= 1'b0;
      ct_o       <= 1'b0;
    end else begin
      ct_valid_o <= accept;
      if (accept) begin
        ks_o <= z;
        ct_o <= pt_i ^ z;
      end
    end
  end
endmodule

// File: rtl/trv_keystream_chk.sv
module trv_keystream_chk #(
  parameter int WARMUP_CYCLES = 1152
) (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic pt_i,
  input logic ct_o,
  input logic ks_o,
  input logic ct_valid_o,
  input logic ks_ready_o
);
  localparam int CW = $clog2(WARMUP_CYCLES + 2);

  logic [CW-1:0] since_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                since_q <= '0;
    else if (start_i)           since_q <= '0;
    else if (since_q != {CW{1'b1}}) since_q <= since_q + 1'b1;
  end

  assert_warmup_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ks_ready_o) |-> since_q == CW'(WARMUP_CYCLES));

  assert_ready_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ks_ready_o && !start_i) |=> ks_ready_o);

  assert_silent_warm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ks_ready_o |=> !ct_valid_o);

  assert_xor_out_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ct_valid_o |-> (ct_o == ($past(pt_i) ^ ks_o)));

  assert_load_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!ks_ready_o && !ct_valid_o));
endmodule

bind trv_keystream trv_keystream_chk #(.WARMUP_CYCLES(WARMUP_CYCLES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .pt_i(pt_i),
  .ct_o(ct_o), .ks_o(ks_o), .ct_valid_o(ct_valid_o), .ks_ready_o(ks_ready_o)
);

// File: tb/test_trv_keystream.sv
`timescale 1ns/1ps
module test_trv_keystream;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [79:0] key_i = '0;
  logic [79:0] iv_i = '0;
  logic        pt_i = 1'b0;
  logic        pt_valid_i = 1'b0;
  logic        ct_o, ks_o, ct_valid_o, ks_ready_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [287:0] ref_s;
  logic [63:0]  msg, cph;

  always #4 clk_i = ~clk_i;

  trv_keystream i_trv_keystream (
    .clk_i, .rst_ni, .start_i, .key_i, .iv_i, .pt_i, .pt_valid_i,
    .ct_o, .ks_o, .ct_valid_o, .ks_ready_o
  );

  // reference model, bit p of the requirements is s[p-1]
  function automatic logic [287:0] ref_load(logic [79:0] k, logic [79:0] v);
    logic [287:0] s = '0;
    for (int i = 0; i < 80; i++) begin
      s[i]      = v[i];
      s[93 + i] = k[i];
    end
    s[285] = 1'b1; s[286] = 1'b1; s[287] = 1'b1;
    return s;
  endfunction

  function automatic logic ref_out(logic [287:0] s);
    return s[65] ^ s[92] ^ s[161] ^ s[176] ^ s[242] ^ s[287];
  endfunction

  function automatic logic [287:0] ref_next(logic [287:0] s);
    logic [287:0] r;
    logic n1, n2, n3;
    n1 = s[65]  ^ s[92]  ^ (s[90]  & s[91])  ^ s[170];
    n2 = s[161] ^ s[176] ^ (s[174] & s[175]) ^ s[263];
    n3 = s[242] ^ s[287] ^ (s[285] & s[286]) ^ s[68];
    r = s << 1;
    r[0] = n3; r[93] = n1; r[177] = n2;
    return r;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_load(input logic [79:0] k, input logic [79:0] v, input logic collide);
    @(negedge clk_i);
    start_i = 1'b1; key_i = k; iv_i = v; pt_valid_i = collide; pt_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0; pt_valid_i = 1'b0;
    chk(ct_valid_o == 1'b0, "R7 no output on load", 32'(ct_valid_o), 0);
    chk(ks_ready_o == 1'b0, "R7 ready drops on load", 32'(ks_ready_o), 0);
    ref_s = ref_load(k, v);
    for (int w = 0; w < 1152; w++) ref_s = ref_next(ref_s);
    for (int w = 1; w <= 1152; w++) begin
      pt_valid_i = 1'($urandom % 2);
      pt_i       = 1'($urandom % 2);
      @(negedge clk_i);
      if (w == 1151) chk(ks_ready_o == 1'b0, "R2 not ready at 1151", 32'(ks_ready_o), 0);
      if (w == 1152) chk(ks_ready_o == 1'b1, "R2 ready at 1152", 32'(ks_ready_o), 1);
      if (ct_valid_o) chk(1'b0, "R3 output during warm-up", 32'(ct_valid_o), 0);
    end
    checks++;
    pt_valid_i = 1'b0;
  endtask

  task automatic xfer(input logic v, input logic p, output logic c);
    logic z;
    pt_valid_i = v; pt_i = p;
    @(negedge clk_i);
    pt_valid_i = 1'b0;
    if (v) begin
      z = ref_out(ref_s);
      chk(ct_valid_o == 1'b1, "R5 valid", 32'(ct_valid_o), 1);
      chk(ks_o == z, "R4 keystream bit", 32'(ks_o), 32'(z));
      chk(ct_o == (p ^ z), "R5 ciphertext bit", 32'(ct_o), 32'(p ^ z));
      ref_s = ref_next(ref_s);
    end else begin
      chk(ct_valid_o == 1'b0, "R6 idle no output", 32'(ct_valid_o), 0);
    end
    c = ct_o;
  endtask

  task automatic stream(input int n, input bit gaps);
    logic c;
    for (int i = 0; i < n; i++) begin
      xfer(gaps ? 1'($urandom % 4 != 0) : 1'b1, 1'($urandom % 2), c);
    end
  endtask

  function automatic logic [79:0] rnd80();
    return {16'($urandom), $urandom, $urandom};
  endfunction

  initial begin
    int seed;
    logic c;
    logic [79:0] k1, v1, k2, v2;
    seed = $urandom(32'd20250);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ks_ready_o == 1'b0, "R8 reset ready", 32'(ks_ready_o), 0);
    chk(ct_valid_o == 1'b0, "R8 reset valid", 32'(ct_valid_o), 0);
    for (int i = 0; i < 8; i++) begin
      pt_valid_i = 1'b1; pt_i = 1'($urandom % 2);
      @(negedge clk_i);
      chk(ct_valid_o == 1'b0, "R8 input before load ignored", 32'(ct_valid_o), 0);
    end
    pt_valid_i = 1'b0;

    // R1 R4: directed all-zero and all-one pairs, then random pairs
    do_load('0, '0, 1'b0);
    stream(150, 1'b0);
    do_load('1, '1, 1'b0);
    stream(150, 1'b1);
    for (int n = 0; n < 3; n++) begin
      do_load(rnd80(), rnd80(), 1'b0);
      stream(200, 1'b1);
    end

    // R9: round trip
    k1 = rnd80(); v1 = rnd80();
    msg = {$urandom, $urandom};
    do_load(k1, v1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      xfer(1'b1, msg[i], c);
      cph[i] = c;
      if (i % 7 == 3) xfer(1'b0, 1'b0, c);
    end
    do_load(k1, v1, 1'b0);
    for (int i = 0; i < 64; i++) begin
      xfer(1'b1, cph[i], c);
      chk(c == msg[i], "R9 plaintext restored", 32'(c), 32'(msg[i]));
    end

    // R7: abort during warm-up
    k2 = rnd80(); v2 = rnd80();
    @(negedge clk_i);
    start_i = 1'b1; key_i = rnd80(); iv_i = rnd80();
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (500) @(negedge clk_i);
    do_load(k2, v2, 1'b0);
    stream(100, 1'b1);

    // R7: load and data bit in the same cycle while running
    do_load(rnd80(), rnd80(), 1'b1);
    stream(100, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule